// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

A purely combinational integer arithmetic-logic unit made from a row of identical one-bit cells. Each cell holds an AND gate, an OR gate, a full adder and a four-way output selector. The cells share three controls. A two-bit function select picks the output path. An A-invert line complements operand A in every cell. A B-negate line complements operand B in every cell and also supplies the carry into cell 0, so the adder forms A + ~B + 1 when subtracting. The carry ripples from cell to cell.

The controls combine to give AND, OR, add, subtract, NOR and signed set-less-than. For set-less-than, the adder sum of the top cell is fed back to the comparison input of cell 0, and every other cell's comparison input is tied low. The unit reports a zero flag, which a branch unit reads after a subtract to test equality. It also reports signed overflow, taken as the carry into the top bit XOR the carry out of it. The raw carry out of the top bit is brought out as well, for unsigned compares. The datapath has no handshake because there is no stream: results follow the inputs within the same cycle.

Top module: `bitslice_alu`

## Requirements
- R1: fn_sel=00 with a_inv=0 and b_neg=0 gives res = opa & opb.
- R2: fn_sel=01 with a_inv=0 and b_neg=0 gives res = opa | opb.
- R3: fn_sel=10 with a_inv=0 and b_neg=0 gives res = (opa + opb) mod 2^W. cout is the unsigned carry out of bit W-1.
- R4: fn_sel=10 with a_inv=0 and b_neg=1 gives res = (opa - opb) mod 2^W. cout is 1 exactly when opa >= opb as unsigned values.
- R5: fn_sel=00 with a_inv=1 and b_neg=1 gives res = ~(opa | opb), which is NOR.
- R6: fn_sel=11 with a_inv=0 and b_neg=1 gives res[W-1:1] = 0 and res[0] = bit W-1 of (opa - opb). This equals the signed test opa < opb when the subtract does not overflow, and is its inverse when it does.
- R7: zero is 1 exactly when every bit of res is 0, whatever the operation.
- R8: ovf is the signed overflow of the adder. For an add it is 1 when both operands have the same sign and the sum's sign differs. For a subtract it is 1 when the operands differ in sign and the difference's sign differs from opa.
- R9: The invert lines act on every path. fn_sel=01 with a_inv=1 and b_neg=1 gives res = ~(opa & opb), which is NAND.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W (32) | Operand A |
| opb | input | W (32) | Operand B |
| fn_sel | input | 2 | Output path: 00 AND, 01 OR, 10 adder sum, 11 less-than |
| a_inv | input | 1 | Complement A in every cell |
| b_neg | input | 1 | Complement B in every cell and carry 1 into cell 0 |
| res | output | W (32) | Result word |
| zero | output | 1 | High when res is all zeros |
| ovf | output | 1 | Signed overflow of the adder |
| cout | output | 1 | Carry out of the top cell |

## Verification
Operands 0, -1, the most negative value and the most positive value are paired in every arithmetic mode. Together with random words, these pairs show whether the carry chain is broken or the carry into cell 0 is dropped: the sum would then be off by one on subtract, and cout would be wrong when opa equals opb. Set-less-than is driven with pairs whose difference overflows. A design that took the signed compare instead of the raw top sum bit, or that fed the wrong cell back, would return the opposite bit there. The overflow corners catch a flag built from the wrong carries: it would fire on -1 + 1 or miss MAX + 1. Equal-operand subtracts exercise the zero flag.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_SUM  = 2'b10,
    FN_LESS = 2'b11
  } fn_e;
endpackage

// File: rtl/alu_cell.sv
module alu_cell
  import alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic a_inv_i,
  input  logic b_neg_i,
  input  logic cin_i,
  input  logic less_i,
  input  fn_e  fn_i,
  output logic res_o,
  output logic sum_o,
  output logic cout_o
);
  logic a_eff, b_eff;

  assign a_eff  = a_i ^ a_inv_i;
  assign b_eff  = b_i ^ b_neg_i;
  assign sum_o  = a_eff ^ b_eff ^ cin_i;
  assign cout_o = (a_eff & b_eff) | (a_eff & cin_i) | (b_eff & cin_i);

  always_comb begin
    unique case (fn_i)
      FN_AND:  res_o = a_eff & b_eff;
      FN_OR:   res_o = a_eff | b_eff;
      FN_SUM:  res_o = sum_o;
      FN_LESS: res_o = less_i;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         msb_cin_i,
  input  logic         msb_cout_i,
  output logic         zero_o,
  output logic         ovf_o
);
  // zero: wide NOR over the result word
  assign zero_o = ~(|res_i);
  // overflow: top carry in and out disagree
  assign ovf_o  = msb_cin_i ^ msb_cout_i;
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   fn_sel,
  input  logic         a_inv,
  input  logic         b_neg,
  output logic [W-1:0] res,
  output logic         zero,
  output logic         ovf,
  output logic         cout
);
  localparam int TOP = W - 1;

  fn_e  fn;
  logic set_bit;
  logic msb_cin;

  assign fn = fn_e'(fn_sel);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ci, co, sm, rs;
    if (i == 0) begin : g_first
      assign ci = b_neg;
    end else begin : g_rest
      assign ci = g_bit[i-1].co;
    end
    alu_cell u_cell (
      .a_i     (opa[i]),
      .b_i     (opb[i]),
      .a_inv_i (a_inv),
      .b_neg_i (b_neg),
      .cin_i   (ci),
      .less_i  ((i == 0) ? set_bit : 1'b0),
      .fn_i    (fn),
      .res_o   (rs),
      .sum_o   (sm),
      .cout_o  (co)
    );
    assign res[i] = rs;
  end

  // top-cell sum fed back as the less-than bit
  assign set_bit = g_bit[TOP].sm;
  assign msb_cin = g_bit[TOP].ci;
  assign cout    = g_bit[TOP].co;

  alu_flags #(.W(W)) u_flags (
    .res_i      (res),
    .msb_cin_i  (msb_cin),
    .msb_cout_i (cout),
    .zero_o     (zero),
    .ovf_o      (ovf)
  );
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [1:0]   fn_sel,
  input logic         a_inv,
  input logic         b_neg,
  input logic [W-1:0] res,
  input logic         zero,
  input logic         ovf,
  input logic         cout
);
  logic [W:0] wide_sum;
  logic [W-1:0] diff;
  assign wide_sum = {1'b0, opa} + {1'b0, opb};
  assign diff     = opa - opb;

  always_comb begin
    if (fn_sel == 2'b00 && !a_inv && !b_neg)
      assert_and_R1: assert (res == (opa & opb));
    if (fn_sel == 2'b10 && !a_inv && !b_neg)
      assert_add_R3: assert ({cout, res} == wide_sum);
    if (fn_sel == 2'b10 && !a_inv && b_neg)
      assert_sub_R4: assert (res == diff && cout == (opa >= opb));
    if (fn_sel == 2'b00 && a_inv && b_neg)
      assert_nor_R5: assert (res == ~(opa | opb));
    if (fn_sel == 2'b11 && !a_inv && b_neg)
      assert_slt_R6: assert (res == {{(W-1){1'b0}}, diff[W-1]});
    if (fn_sel == 2'b10 && !a_inv && b_neg && opa == opb)
      assert_eq_zero_R7: assert (zero);
    if (fn_sel == 2'b10 && !a_inv && !b_neg)
      assert_no_overflow_R8: assert (ovf == ((opa[W-1] == opb[W-1]) && (res[W-1] != opa[W-1])));
  end
endmodule

bind bitslice_alu bitslice_alu_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .fn_sel(fn_sel), .a_inv(a_inv), .b_neg(b_neg),
  .res(res), .zero(zero), .ovf(ovf), .cout(cout)
);

// File: tb/sim_bitslice_alu.sv
`timescale 1ns/1ps
module sim_bitslice_alu;
  localparam int W = 32;
  localparam logic [W-1:0] MAXP = 32'h7FFF_FFFF;
  localparam logic [W-1:0] MINN = 32'h8000_0000;
  localparam logic [W-1:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] opa, opb, res;
  logic [1:0]   fn_sel;
  logic         a_inv, b_neg, zero, ovf, cout;
  int n_chk = 0, n_bad = 0, cyc = 0;

  bitslice_alu #(.W(W)) u0 (
    .opa(opa), .opb(opb), .fn_sel(fn_sel), .a_inv(a_inv), .b_neg(b_neg),
    .res(res), .zero(zero), .ovf(ovf), .cout(cout)
  );

  logic [W-1:0] corner [4];
  initial begin
    corner[0] = '0; corner[1] = ONES; corner[2] = MINN; corner[3] = MAXP;
  end

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h)", req, got, exp, opa, opb);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] f, input logic ai, input logic bn);
    @(negedge clk);
    opa = a; opb = b; fn_sel = f; a_inv = ai; b_neg = bn;
    #2;
  endtask

  task automatic check_zero();
    chk("R7 zero", {31'b0, zero}, {31'b0, res == '0});
  endtask

  task automatic t_idle();
    drive('0, '0, 2'b00, 1'b0, 1'b0);
    chk("R1 idle res", res, '0);
    chk("R7 idle zero", {31'b0, zero}, 32'd1);
  endtask

  task automatic t_and_or(input logic [W-1:0] a, input logic [W-1:0] b);
    drive(a, b, 2'b00, 1'b0, 1'b0);
    chk("R1 and", res, a & b); check_zero();
    drive(a, b, 2'b01, 1'b0, 1'b0);
    chk("R2 or", res, a | b); check_zero();
  endtask

  task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    logic exp_ovf;
    s = {1'b0, a} + {1'b0, b};
    exp_ovf = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
    drive(a, b, 2'b10, 1'b0, 1'b0);
    chk("R3 add res", res, s[W-1:0]);
    chk("R3 add cout", {31'b0, cout}, {31'b0, s[W]});
    chk("R8 add ovf", {31'b0, ovf}, {31'b0, exp_ovf});
    check_zero();
  endtask

  task automatic t_sub(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] d;
    logic exp_ovf;
    d = a - b;
    exp_ovf = (a[W-1] != b[W-1]) && (d[W-1] != a[W-1]);
    drive(a, b, 2'b10, 1'b0, 1'b1);
    chk("R4 sub res", res, d);
    chk("R4 sub cout", {31'b0, cout}, {31'b0, a >= b});
    chk("R8 sub ovf", {31'b0, ovf}, {31'b0, exp_ovf});
    chk("R7 sub zero", {31'b0, zero}, {31'b0, a == b});
  endtask

  task automatic t_nor_nand(input logic [W-1:0] a, input logic [W-1:0] b);
    drive(a, b, 2'b00, 1'b1, 1'b1);
    chk("R5 nor", res, ~(a | b)); check_zero();
    drive(a, b, 2'b01, 1'b1, 1'b1);
    chk("R9 nand", res, ~(a & b)); check_zero();
  endtask

  task automatic t_slt(input logic [W-1:0] a, input logic [W-1:0] b);
    logic lt, v;
    lt = $signed(a) < $signed(b);
    v  = (a[W-1] != b[W-1]) && ((a - b) >> (W-1)) != {31'b0, a[W-1]};
    drive(a, b, 2'b11, 1'b0, 1'b1);
    chk("R6 slt", res, {31'b0, lt ^ v});
    check_zero();
  endtask

  initial begin
    opa = '0; opb = '0; fn_sel = '0; a_inv = 0; b_neg = 0;
    t_idle();
    // directed overflow corners
    t_add(MAXP, 32'd1);       // R8 positive overflow
    t_add(ONES, 32'd1);       // R3 carry out, no overflow
    t_add(MINN, MINN);        // R8 negative overflow
    t_sub(MINN, 32'd1);       // R8 sub overflow
    t_sub(32'd5, 32'd5);      // R7 equal
    t_slt(MINN, 32'd1);       // R6 overflow case: raw bit is 0
    t_slt(32'd3, 32'd9);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        t_and_or(corner[i], corner[j]);
        t_add(corner[i], corner[j]);
        t_sub(corner[i], corner[j]);
        t_nor_nand(corner[i], corner[j]);
        t_slt(corner[i], corner[j]);
      end
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom(); rb = (k % 5 == 0) ? ra : $urandom();
      t_and_or(ra, rb);
      t_add(ra, rb);
      t_sub(ra, rb);
      t_nor_nand(ra, rb);
      t_slt(ra, rb);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule